// File: doc/BRIEF.md
# Interface Clock and Reset Sequencer

This block holds one 32-bit control word that brings up the clocking and resets of a parallel disk interface host. Software writes the word through a simple word-addressed register port. Three of its bits gate the interface clocks. One bit picks the interface timing rate. One bit requests a core reset handshake. One bit releases the disk bus reset. One bit is a plain buffer-mode control. The outputs drive the clock gating, the timing rate select, the core reset and the bus reset.

Completion of the core reset is not immediate. Once the core-reset request is set and both the local and the output clock enables are on, an internal settle counter runs for a set number of cycles. Only after that does the request bit read back as 1 and the core reset deassert. Software is expected to poll for that readback before it releases the bus reset. A release attempted too early is dropped, and a sticky ordering-error flag is raised. Writing an all-zero word returns the block to its powered-down state.

Top module: `clkrst_seq`

## Requirements
- R1: After a synchronous active-low reset, all clock enables and the rate select are 0, the core reset and the bus reset are asserted (1), the ordering-error flag is 0 and the register reads 0.
- R2: Bit 0 drives the local clock enable, bit 1 drives the interface clock output enable and bit 8 drives the output clock enable. Each bit reads back as written. The rate select output is 1 (fast timing) exactly when bit 1 is set.
- R3: After bit 16 (core-reset request) is written 1 while bits 0 and 8 are 1, bit 16 reads 0 and the core reset stays asserted for the next SETTLE_CYC-1 cycles. From the SETTLE_CYC-th clock edge after the write, bit 16 reads 1 and the core reset deasserts.
- R4: The settle counter runs only while bits 0 and 8 are both 1. Clearing either one makes bit 16 read 0 and reasserts the core reset. Completion then needs a full fresh settle period.
- R5: Writing bit 18 as 1 while bit 16 reads 1 deasserts the bus reset, and bit 18 then reads 1. The bus reset is never released while the core reset is asserted.
- R6: Writing bit 18 as 1 while bit 16 reads 0 is ignored: bit 18 reads 0 and the bus reset stays asserted. The ordering-error flag is set, and it stays set until the block reset, even across an all-zero write.
- R7: A write of the all-zero word clears every clock enable and restarts the settle counter from zero. It asserts the core reset and the bus reset.
- R8: Bit 17 is a read/write buffer-mode bit driving its own output. All bits other than 0, 1, 8, 16, 17 and 18 read 0 and ignore writes.
- R9: A write to any word address other than REG_WADDR (default 0x3FC, byte offset 0xFF0) changes nothing, and a read of any other word address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lclk_en | output | 1 | Local clock enable |
| ifclk_oe | output | 1 | Interface clock output enable |
| oclk_en | output | 1 | Output clock enable |
| rate_fast | output | 1 | 1 = fast interface timing, 0 = slow |
| buf_mode | output | 1 | Buffer mode control |
| core_rst | output | 1 | Core reset, active high |
| ata_bus_rst | output | 1 | Disk bus reset, active high |
| seq_err | output | 1 | Sticky ordering-error flag |

## Verification
A wrong settle count shows up at the bus port and on core_rst within one cycle of the expected completion edge. The bench therefore reads the word one cycle before and one cycle at the SETTLE_CYC boundary, both on first bring-up and after a clock drop and a zero write. A lost gating term or a stale counter shows up as early completion right after a clock drop or a zero write. A wrong ordering check shows up at once: bus reset released too early, bit 18 read back, or seq_err not set or not held.

// File: rtl/clkrst_pkg.sv
// Package: bit positions of the control word and shared widths.
// Assumes a 32-bit data path; the positions are fixed by software.
package clkrst_pkg;
    localparam int DATA_W     = 32;
    localparam int BIT_LCLK   = 0;
    localparam int BIT_IFCLK  = 1;
    localparam int BIT_OCLK   = 8;
    localparam int BIT_CREQ   = 16;
    localparam int BIT_BUF    = 17;
    localparam int BIT_BUSREL = 18;

    // Stored control fields of the word
    typedef struct packed {
        logic lclk;
        logic ifclk;
        logic oclk;
        logic creq;
        logic bufm;
        logic busrel;
    } ctl_t;
endpackage

// File: rtl/clkrst_settle.sv
// Settle counter: counts cycles while the core-reset request and both
// clock enables are on, saturating at SETTLE_CYC, and flags completion.
// Assumes SETTLE_CYC >= 1. A synchronous clear restarts the count.
module clkrst_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    // Advance the count while running, hold at the limit, drop otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Completion only counts while the run condition still holds
    always_comb begin
        done = run && (cnt_q == CNT_MAX);
    end

    // R3: completion appears only after a full count under run
    a_r3_settle_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(run) && $past(cnt_q) == CNT_MAX - 1'b1)
                     || ($past(run) && $past(cnt_q) == CNT_MAX));

    // R4: losing the run condition clears the count on the next edge
    a_r4_gate_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/clkrst_regfile.sv
// Control word storage: decodes writes at one word address, applies the
// ordering rule for the bus-reset release, keeps the sticky error flag
// and forms the read data. Assumes one write strobe per access.
module clkrst_regfile
    import clkrst_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] REG_WADDR = 10'h3FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              done,
    output logic [DATA_W-1:0] bus_rdata,
    output ctl_t              ctl,
    output logic              zero_wr,
    output logic              seq_err
);
    logic hit;
    logic wr_hit;
    logic early_rel;
    ctl_t ctl_q;
    logic err_q;

    // Address match and write qualification
    always_comb begin
        hit       = (bus_addr == REG_WADDR);
        wr_hit    = bus_wr && hit;
        zero_wr   = wr_hit && (bus_wdata == '0);
        early_rel = wr_hit && bus_wdata[BIT_BUSREL] && !done;
    end

    // Store the writable fields; the release bit only lands after completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_hit) begin
            ctl_q.lclk   <= bus_wdata[BIT_LCLK];
            ctl_q.ifclk  <= bus_wdata[BIT_IFCLK];
            ctl_q.oclk   <= bus_wdata[BIT_OCLK];
            ctl_q.creq   <= bus_wdata[BIT_CREQ];
            ctl_q.bufm   <= bus_wdata[BIT_BUF];
            ctl_q.busrel <= bus_wdata[BIT_BUSREL] && done;
        end
    end

    // Sticky ordering error, cleared only by the block reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (early_rel) begin
            err_q <= 1'b1;
        end
    end

    // Read data: live status in the request and release positions
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[BIT_LCLK]   = ctl_q.lclk;
            bus_rdata[BIT_IFCLK]  = ctl_q.ifclk;
            bus_rdata[BIT_OCLK]   = ctl_q.oclk;
            bus_rdata[BIT_CREQ]   = done;
            bus_rdata[BIT_BUF]    = ctl_q.bufm;
            bus_rdata[BIT_BUSREL] = ctl_q.busrel && done;
        end
    end

    assign ctl     = ctl_q;
    assign seq_err = err_q;

    // R6: the error flag never falls once raised
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R6: an early release never stores the release bit
    a_r6_early_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        early_rel |=> !ctl_q.busrel && seq_err);

    // R9: a write elsewhere leaves the stored word alone
    a_r9_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> $stable(ctl_q));
endmodule

// File: rtl/clkrst_seq.sv
// Top: interface clock and reset sequencer. Joins the control word
// storage to the settle counter and drives the clock enables, the rate
// select and both resets. Assumes a synchronous active-low reset.
module clkrst_seq
    import clkrst_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] REG_WADDR = 10'h3FC,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              lclk_en,
    output logic              ifclk_oe,
    output logic              oclk_en,
    output logic              rate_fast,
    output logic              buf_mode,
    output logic              core_rst,
    output logic              ata_bus_rst,
    output logic              seq_err
);
    ctl_t ctl;
    logic done;
    logic zero_wr;
    logic run;

    clkrst_regfile #(
        .ADDR_W    (ADDR_W),
        .REG_WADDR (REG_WADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .done      (done),
        .bus_rdata (bus_rdata),
        .ctl       (ctl),
        .zero_wr   (zero_wr),
        .seq_err   (seq_err)
    );

    // Counter runs only with the request and both gated clocks present
    always_comb begin
        run = ctl.creq && ctl.lclk && ctl.oclk;
    end

    clkrst_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (zero_wr),
        .done  (done)
    );

    // Output mapping of clocks, rate and resets
    always_comb begin
        lclk_en     = ctl.lclk;
        ifclk_oe    = ctl.ifclk;
        oclk_en     = ctl.oclk;
        rate_fast   = ctl.ifclk;
        buf_mode    = ctl.bufm;
        core_rst    = !done;
        ata_bus_rst = !(ctl.busrel && done);
    end

    // R5: bus reset released only with the core out of reset
    a_r5_bus_after_core: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_bus_rst |-> !core_rst);

    // R7: an all-zero write returns to the powered-down state
    a_r7_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_WADDR && bus_wdata == '0)
        |=> (!lclk_en && !ifclk_oe && !oclk_en && core_rst && ata_bus_rst));

    // R4: a missing clock enable keeps the core in reset
    a_r4_clock_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (!lclk_en || !oclk_en) |-> core_rst);
endmodule

// File: tb/clkrst_seq_bench.sv
// Scoreboard bench: driver tasks queue expected observations; a monitor
// pops and compares them at the falling clock edge.
module clkrst_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 16;
    localparam logic [9:0] RADDR = 10'h3FC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = RADDR;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic lclk_en, ifclk_oe, oclk_en, rate_fast, buf_mode;
    logic core_rst, ata_bus_rst, seq_err;

    clkrst_seq #(.ADDR_W(10), .REG_WADDR(10'h3FC), .SETTLE_CYC(SETTLE)) u_clkrst_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lclk_en(lclk_en),
        .ifclk_oe(ifclk_oe), .oclk_en(oclk_en), .rate_fast(rate_fast),
        .buf_mode(buf_mode), .core_rst(core_rst), .ata_bus_rst(ata_bus_rst),
        .seq_err(seq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] rd;
        logic [7:0]  ob;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Observation vector: core, bus, err, lclk, ifclk, oclk, rate, buf
    function automatic logic [7:0] mk(input logic c, input logic b, input logic e,
                                      input logic l, input logic i, input logic o,
                                      input logic m);
        return {c, b, e, l, i, o, i, m};
    endfunction

    // Monitor: compare queued expectations against the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = sb_q.pop_front();
            got = {core_rst, ata_bus_rst, seq_err, lclk_en, ifclk_oe, oclk_en, rate_fast, buf_mode};
            n_checks++;
            if (bus_rdata !== it.rd) begin
                n_errors++;
                $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.rd);
            end
            n_checks++;
            if (got !== it.ob) begin
                n_errors++;
                $display("FAIL %s outputs actual=%b expected=%b", it.tag, got, it.ob);
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
        bus_addr  = RADDR;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic observe(input logic [9:0] a, input logic [31:0] rd,
                           input logic [7:0] ob, input string tag);
        item_t it;
        bus_addr = a;
        it.rd = rd; it.ob = ob; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
        bus_addr = RADDR;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        observe(RADDR, 32'h0, mk(1,1,0,0,0,0,0), "R1 reset");
        // R2 bring-up order: zero, then rate bit, then clocks
        wr(RADDR, 32'h0);
        wr(RADDR, 32'h2);
        observe(RADDR, 32'h2, mk(1,1,0,0,1,0,0), "R2 rate fast");
        wr(RADDR, 32'h103);
        observe(RADDR, 32'h103, mk(1,1,0,1,1,1,0), "R2 clocks on");
        // R6 early release
        wr(RADDR, 32'h0004_0103);
        observe(RADDR, 32'h103, mk(1,1,1,1,1,1,0), "R6 early release");
        // R3 settle boundary
        wr(RADDR, 32'h0001_0103);
        idle(SETTLE - 1);
        observe(RADDR, 32'h103, mk(1,1,1,1,1,1,0), "R3 before settle");
        idle(1);
        observe(RADDR, 32'h0001_0103, mk(0,1,1,1,1,1,0), "R3 settled");
        // R5 release after completion, R6 flag still held
        wr(RADDR, 32'h0005_0103);
        observe(RADDR, 32'h0005_0103, mk(0,0,1,1,1,1,0), "R5 bus released");
        // R8 unlisted bits, buffer mode
        wr(RADDR, 32'hFFFF_FFFF);
        observe(RADDR, 32'h0007_0103, mk(0,0,1,1,1,1,1), "R8 mask");
        // R9 other address
        wr(10'h000, 32'h0);
        observe(RADDR, 32'h0007_0103, mk(0,0,1,1,1,1,1), "R9 miss write");
        observe(10'h001, 32'h0, mk(0,0,1,1,1,1,1), "R9 miss read");
        // R4 dropping local clock
        wr(RADDR, 32'h0007_0102);
        observe(RADDR, 32'h0002_0102, mk(1,1,1,0,1,1,1), "R4 clock drop");
        wr(RADDR, 32'h0003_0103);
        idle(SETTLE - 1);
        observe(RADDR, 32'h0002_0103, mk(1,1,1,1,1,1,1), "R4 fresh settle");
        idle(1);
        observe(RADDR, 32'h0003_0103, mk(0,1,1,1,1,1,1), "R4 resettled");
        // R7 zero write restarts everything
        wr(RADDR, 32'h0);
        observe(RADDR, 32'h0, mk(1,1,1,0,0,0,0), "R7 zero write");
        wr(RADDR, 32'h0001_0103);
        idle(SETTLE - 1);
        observe(RADDR, 32'h103, mk(1,1,1,1,1,1,0), "R7 restart count");
        idle(1);
        observe(RADDR, 32'h0001_0103, mk(0,1,1,1,1,1,0), "R7 restart done");
        idle(2);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule